// File: doc/BRIEF.md
# Two-Phase Regulator Mode Controller

This block selects the operating mode of a two-phase buck regulator. Three active-state control inputs are decoded into a requested mode: full two-phase continuous conduction, one-phase continuous conduction, or one-phase diode emulation. The controller then moves its mode state toward that request under timing rules. Lower-power modes are entered only after the request has been held for a number of switching periods. Dropping a phase waits for any reference-voltage ramp to finish. A change of the reference code while in diode emulation returns the regulator at once to full two-phase operation.

An internal period counter provides the time base. It counts system clocks per switching period and issues a start pulse for phase 1 at the period boundary and one for phase 2 half a period later. The boundary pulse is also the switching-period tick. When phase 2 is idled, the controller keeps it running in a shedding state until the idling phase reports zero current. A board strap forces permanent one-phase operation with diode emulation. Current sensing, balancing, PWM and ramp synthesis lie outside the block. The zero-current condition arrives as a plain input.

Top module: `mpc_mode_ctrl`

## Requirements
- R1: The request decodes as follows. Diode emulation when `deep_sleep_i`=1 and `stop_n_i`=0, whatever `psi_n_i` is. For every other combination, two-phase when `psi_n_i`=1 and one-phase when `psi_n_i`=0.
- R2: Leaving two-phase operation requires a non-two-phase request held unchanged while the hold counter passes 2 ticks. The counter advances by one on each tick. The transition happens at a tick where the counter already reads at least 2. Shorter requests leave the mode at two-phase.
- R3: Diode emulation is entered from one-phase mode only at a tick where the unchanged diode request has a hold count of at least 7. Shorter requests leave the mode at one-phase.
- R4: No transition out of two-phase mode is taken at a tick while `ramp_busy_i`=1. The pending drop proceeds at a later tick once the input is low.
- R5: In diode emulation, any change of `ref_code_i` from its value in the previous clock returns the mode to two-phase on the next clock edge, without waiting for a tick.
- R6: While `one_phase_strap_i`=1, `ph2_en_o`=0, `dcm_en_o`=1 and `mode_o` reads diode emulation. The internal state is held at two-phase.
- R7: `ph1_start_o` pulses for one clock every PERIOD_CLKS clocks at counter value 0. `ph2_start_o` pulses at counter value PERIOD_CLKS/2. The counter reads 0 in the first clock after reset.
- R8: A phase drop enters a shedding state in which `ph2_en_o` stays 1. The clock edge after `zero_cur_i`=1 moves the mode to one-phase with `ph2_en_o`=0.
- R9: A two-phase request at a tick leaves one-phase, shedding or diode mode directly for two-phase. A one-phase request at a tick leaves diode emulation for one-phase. No hold count applies to either.
- R10: The hold counter clears whenever the decoded request differs from the previous clock's request or the reference code changes. It saturates at 7.
- R11: Reset (`rst_n`=0) gives mode two-phase, `ph2_en_o`=1 and `dcm_en_o`=0, with the period counter and hold counter at 0.
- R12: `mode_o` encodes 00 two-phase, 01 one-phase, 10 diode emulation, 11 shedding. `dcm_en_o` is 1 only in diode emulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| deep_sleep_i | input | 1 | Deep-sleep control input, active high |
| stop_n_i | input | 1 | Stop-clock control input, active low |
| psi_n_i | input | 1 | Low-power-state control input, active low |
| one_phase_strap_i | input | 1 | Board strap forcing one-phase diode operation |
| ramp_busy_i | input | 1 | Reference-voltage ramp in progress |
| ref_code_i | input | REF_W | Reference-voltage code |
| zero_cur_i | input | 1 | Idling phase has reached zero current |
| ph2_en_o | output | 1 | Phase 2 enable |
| dcm_en_o | output | 1 | Diode emulation enable for phase 1 |
| mode_o | output | 2 | Mode status code |
| ph1_start_o | output | 1 | Phase 1 start pulse, also the period tick |
| ph2_start_o | output | 1 | Phase 2 start pulse, half a period later |

## Verification
The bench targets request pulses one tick short of each filter length. A design that counted the wrong number of periods, or did not clear the count on a request change, would drop a phase or enable diode emulation on a glitch. It also raises a phase-drop request during an active ramp and checks that a premature drop is caught. A reference-code change during diode emulation must exit within a single clock and not at the next tick. Shedding with zero current held low confirms that phase 2 is never cut before its current reaches zero. The strap override and the half-period placement of the phase-2 start pulse are compared cycle by cycle against a model built from the requirements.

// File: rtl/mpc_pkg.sv
`timescale 1ns/1ps
package mpc_pkg;

  // Mode status code seen at mode_o (R12)
  typedef enum logic [1:0] {
    MODE_DUAL   = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_DIODE  = 2'b10,
    MODE_SHED   = 2'b11
  } mode_e;

  // Decoded request
  typedef enum logic [1:0] {
    REQ_DUAL   = 2'b00,
    REQ_SINGLE = 2'b01,
    REQ_DIODE  = 2'b10
  } req_e;

  // Control-input decode (R1)
  function automatic req_e decode_req(input logic deep, input logic stop_n,
                                      input logic psi_n);
    req_e r;
    if (deep && !stop_n) r = REQ_DIODE;
    else if (psi_n)      r = REQ_DUAL;
    else                 r = REQ_SINGLE;
    return r;
  endfunction

endpackage

// File: rtl/mpc_period_gen.sv
`timescale 1ns/1ps
module mpc_period_gen #(
  parameter int PERIOD_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph1_start_o,
  output logic ph2_start_o
);

  localparam int CNT_W = (PERIOD_CLKS > 2) ? $clog2(PERIOD_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CLKS - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(PERIOD_CLKS / 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ph1_start_o = (cnt_q == '0);
  assign ph2_start_o = (cnt_q == HALF);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R7
  AST_STARTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_start_o |=> !ph1_start_o); // R7

endmodule

// File: rtl/mpc_req_filter.sv
`timescale 1ns/1ps
module mpc_req_filter
  import mpc_pkg::*;
#(
  parameter int HOLD_MAX = 7,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  req_e          req_i,
  input  logic          clear_i,
  output logic [CW-1:0] hold_o,
  output logic          steady_o
);

  localparam logic [CW-1:0] SAT = CW'(HOLD_MAX);

  req_e          last_q, last_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          changed;

  assign changed = (req_i != last_q) || clear_i;

  always_comb begin
    last_d = req_i;
    hold_d = hold_q;
    if (changed)                        hold_d = '0;
    else if (tick_i && (hold_q != SAT)) hold_d = hold_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= REQ_DUAL;
      hold_q <= '0;
    end else begin
      last_q <= last_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o   = hold_q;
  assign steady_o = !changed;

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != last_q) |=> (hold_q == '0)); // R10
  AST_HOLD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= SAT); // R10
  AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !changed) |=> $stable(hold_q)); // R10

endmodule

// File: rtl/mpc_mode_fsm.sv
`timescale 1ns/1ps
module mpc_mode_fsm
  import mpc_pkg::*;
#(
  parameter int DROP_HOLD = 2,
  parameter int DCM_HOLD  = 7,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  req_e          req_i,
  input  logic          steady_i,
  input  logic [CW-1:0] hold_i,
  input  logic          ramp_i,
  input  logic          ref_chg_i,
  input  logic          zero_i,
  input  logic          strap_i,
  output mode_e         state_o
);

  mode_e state_q, state_d;
  logic  drop_ok, diode_ok;

  assign drop_ok  = steady_i && (int'(hold_i) >= DROP_HOLD) && !ramp_i;
  assign diode_ok = steady_i && (int'(hold_i) >= DCM_HOLD);

  always_comb begin
    state_d = state_q;
    if (strap_i) begin
      state_d = MODE_DUAL;
    end else if ((state_q == MODE_DIODE) && ref_chg_i) begin
      state_d = MODE_DUAL;
    end else begin
      case (state_q)
        MODE_DUAL: begin
          if (tick_i && (req_i != REQ_DUAL) && drop_ok) state_d = MODE_SHED;
        end
        MODE_SHED: begin
          if (tick_i && (req_i == REQ_DUAL)) state_d = MODE_DUAL;
          else if (zero_i)                   state_d = MODE_SINGLE;
        end
        MODE_SINGLE: begin
          if (tick_i && (req_i == REQ_DUAL))                  state_d = MODE_DUAL;
          else if (tick_i && (req_i == REQ_DIODE) && diode_ok) state_d = MODE_DIODE;
        end
        MODE_DIODE: begin
          if (tick_i && (req_i == REQ_DUAL))        state_d = MODE_DUAL;
          else if (tick_i && (req_i == REQ_SINGLE)) state_d = MODE_SINGLE;
        end
        default: state_d = MODE_DUAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_DUAL;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_DROP_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MODE_SHED) && ($past(state_q) == MODE_DUAL))
      |-> (int'($past(hold_i)) >= DROP_HOLD)); // R2
  AST_DIODE_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MODE_DIODE) && ($past(state_q) == MODE_SINGLE))
      |-> (int'($past(hold_i)) >= DCM_HOLD)); // R3
  AST_NO_DROP_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MODE_SHED) && ($past(state_q) == MODE_DUAL)) |-> !$past(ramp_i)); // R4
  AST_REF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MODE_DIODE) && ref_chg_i && !strap_i) |=> (state_q == MODE_DUAL)); // R5
  AST_SHED_WAITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MODE_SHED) && !zero_i) |=> (state_q != MODE_SINGLE)); // R8
  AST_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ref_chg_i && !strap_i && !((state_q == MODE_SHED) && zero_i))
      |=> $stable(state_q)); // R9

endmodule

// File: rtl/mpc_mode_ctrl.sv
`timescale 1ns/1ps
module mpc_mode_ctrl
  import mpc_pkg::*;
#(
  parameter int PERIOD_CLKS = 8,
  parameter int REF_W       = 6,
  parameter int DROP_HOLD   = 2,
  parameter int DCM_HOLD    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             deep_sleep_i,
  input  logic             stop_n_i,
  input  logic             psi_n_i,
  input  logic             one_phase_strap_i,
  input  logic             ramp_busy_i,
  input  logic [REF_W-1:0] ref_code_i,
  input  logic             zero_cur_i,
  output logic             ph2_en_o,
  output logic             dcm_en_o,
  output logic [1:0]       mode_o,
  output logic             ph1_start_o,
  output logic             ph2_start_o
);

  localparam int HOLD_MAX = (DCM_HOLD > DROP_HOLD) ? DCM_HOLD : DROP_HOLD;
  localparam int CW       = $clog2(HOLD_MAX + 1);

  logic             tick;
  logic [REF_W-1:0] ref_q;
  logic             ref_chg;
  req_e             req;
  logic [CW-1:0]    hold;
  logic             steady;
  mode_e            state;

  mpc_period_gen #(.PERIOD_CLKS(PERIOD_CLKS)) u_period (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph1_start_o (ph1_start_o),
    .ph2_start_o (ph2_start_o)
  );

  assign tick = ph1_start_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_code_i;
  end

  assign ref_chg = (ref_code_i != ref_q);
  assign req     = decode_req(deep_sleep_i, stop_n_i, psi_n_i);

  mpc_req_filter #(.HOLD_MAX(HOLD_MAX), .CW(CW)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .req_i    (req),
    .clear_i  (ref_chg),
    .hold_o   (hold),
    .steady_o (steady)
  );

  mpc_mode_fsm #(.DROP_HOLD(DROP_HOLD), .DCM_HOLD(DCM_HOLD), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .req_i     (req),
    .steady_i  (steady),
    .hold_i    (hold),
    .ramp_i    (ramp_busy_i),
    .ref_chg_i (ref_chg),
    .zero_i    (zero_cur_i),
    .strap_i   (one_phase_strap_i),
    .state_o   (state)
  );

  always_comb begin
    if (one_phase_strap_i) begin
      ph2_en_o = 1'b0;
      dcm_en_o = 1'b1;
      mode_o   = MODE_DIODE;
    end else begin
      ph2_en_o = (state == MODE_DUAL) || (state == MODE_SHED);
      dcm_en_o = (state == MODE_DIODE);
      mode_o   = state;
    end
  end

  AST_STRAP_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    one_phase_strap_i |-> (!ph2_en_o && dcm_en_o)); // R6
  AST_DCM_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    dcm_en_o |-> !ph2_en_o); // R12

endmodule

// File: tb/sim_mpc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_mpc_mode_ctrl;

  localparam int P  = 8;
  localparam int RW = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, deep, stop_n, psi_n, strap, ramp, zero;
  logic [RW-1:0] refc;
  logic          ph2_en, dcm_en, ph1_s, ph2_s;
  logic [1:0]    mode;

  mpc_mode_ctrl #(.PERIOD_CLKS(P), .REF_W(RW), .DROP_HOLD(2), .DCM_HOLD(7)) u0 (
    .clk (clk), .rst_n (rst_n), .deep_sleep_i (deep), .stop_n_i (stop_n),
    .psi_n_i (psi_n), .one_phase_strap_i (strap), .ramp_busy_i (ramp),
    .ref_code_i (refc), .zero_cur_i (zero), .ph2_en_o (ph2_en),
    .dcm_en_o (dcm_en), .mode_o (mode), .ph1_start_o (ph1_s), .ph2_start_o (ph2_s)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string tag_mode = "R12";

  int            m_cnt, m_hold;
  logic [1:0]    m_last, m_state;
  logic [RW-1:0] m_ref;

  function automatic logic [1:0] f_dec(logic d, logic s, logic p);
    if (d && !s) return 2'd2;
    return p ? 2'd0 : 2'd1;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_hold = 0; m_last = 2'd0; m_state = 2'd0; m_ref = '0;
  endtask

  task automatic compare();
    int em;
    em = strap ? 2 : int'(m_state);
    check(tag_mode, int'(mode), em);
    check(strap ? "R6" : "R8", int'(ph2_en), (!strap && (m_state == 0 || m_state == 3)) ? 1 : 0);
    check(strap ? "R6" : "R3", int'(dcm_en), (strap || m_state == 2) ? 1 : 0);
    check("R7", int'(ph1_s), (m_cnt == 0) ? 1 : 0);
    check("R7", int'(ph2_s), (m_cnt == P/2) ? 1 : 0);
  endtask

  task automatic advance();
    logic [1:0] rq, ns;
    bit tk, vc, steady, drop_ok, diode_ok;
    rq = f_dec(deep, stop_n, psi_n);
    tk = (m_cnt == 0);
    vc = (refc != m_ref);
    steady   = (rq == m_last) && !vc;
    drop_ok  = steady && (m_hold >= 2) && !ramp;
    diode_ok = steady && (m_hold >= 7);
    ns = m_state;
    if (strap) ns = 0;
    else if (m_state == 2 && vc) ns = 0;
    else begin
      case (m_state)
        2'd0: if (tk && rq != 0 && drop_ok) ns = 3;
        2'd3: if (tk && rq == 0) ns = 0; else if (zero) ns = 1;
        2'd1: if (tk && rq == 0) ns = 0; else if (tk && rq == 2 && diode_ok) ns = 2;
        default: if (tk && rq == 0) ns = 0; else if (tk && rq == 1) ns = 1;
      endcase
    end
    if (rq != m_last || vc) m_hold = 0;
    else if (tk && m_hold < 7) m_hold++;
    m_last  = rq;
    m_ref   = refc;
    m_cnt   = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    m_state = ns;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      #1;
      compare();
      advance();
      @(negedge clk);
    end
  endtask

  task automatic req_set(logic d, logic s, logic p);
    deep = d; stop_n = s; psi_n = p;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    rst_n = 1'b0; strap = 0; ramp = 0; zero = 0; refc = '0;
    req_set(0, 1, 1);
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", int'(mode), 0);
    check("R11", int'(ph2_en), 1);
    check("R11", int'(dcm_en), 0);
    check("R11", int'(ph1_s), 1);
    rst_n = 1'b1;
    model_reset();
    step(5);

    // R2: one-period glitch of a one-phase request
    tag_mode = "R2";
    req_set(0, 1, 0); step(P);
    req_set(0, 1, 1); step(2 * P);
    check("R2", int'(mode), 0);

    // R8: full drop, shedding until zero current
    tag_mode = "R8";
    req_set(0, 1, 0); step(40);
    check("R8", int'(mode), 3);
    check("R8", int'(ph2_en), 1);
    zero = 1; step(2); zero = 0;
    check("R8", int'(mode), 1);
    check("R8", int'(ph2_en), 0);

    // R3: diode request one tick short, then long enough
    tag_mode = "R3";
    req_set(1, 0, 0); step(6 * P);
    check("R3", int'(mode), 1);
    req_set(0, 1, 0); step(P);
    req_set(1, 0, 1); step(10 * P);
    check("R3", int'(mode), 2);
    check("R3", int'(dcm_en), 1);

    // R5: reference change exits diode emulation in one clock
    tag_mode = "R5";
    refc = 6'd5; step(1);
    check("R5", int'(mode), 0);
    req_set(0, 1, 1); step(3 * P);

    // R4: drop deferred during a ramp
    tag_mode = "R4";
    ramp = 1; req_set(0, 1, 0); step(60);
    check("R4", int'(mode), 0);
    ramp = 0; step(2 * P + 2);
    check("R4", int'(mode), 3);
    zero = 1; step(2); zero = 0;

    // R9: adding a phase needs no filter
    tag_mode = "R9";
    req_set(0, 1, 1); step(P);
    check("R9", int'(mode), 0);

    // R6: strap override
    tag_mode = "R6";
    strap = 1; step(3);
    check("R6", int'(mode), 2);
    check("R6", int'(ph2_en), 0);
    check("R6", int'(dcm_en), 1);
    strap = 0; step(2);
    check("R6", int'(mode), 0);

    // R10: alternating requests and reference changes keep restarting the count
    tag_mode = "R10";
    for (int k = 0; k < 10; k++) begin
      req_set(0, 1, k[0]); step(12);
    end
    req_set(0, 1, 0); step(14);
    refc = 6'd9; step(14);
    check("R10", int'(mode), 0);

    // R1: random stimulus against the model
    tag_mode = "R1";
    for (int c = 0; c < 20000; c++) begin
      if ($urandom_range(0, 39) == 0)
        req_set(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 49) == 0) ramp = ~ramp;
      if ($urandom_range(0, 299) == 0) refc = RW'($urandom_range(0, 63));
      if ($urandom_range(0, 999) == 0) strap = ~strap;
      zero = ($urandom_range(0, 7) == 0);
      step(1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule